// File: doc/BRIEF.md
# Double-Transition Parallel Data Receiver

This block receives 16-bit words from a parallel bus whose only timing reference is a handshake strobe driven by the far end. The strobe is resynchronised into the fast system clock, and its transitions are turned into capture events. In a single-transition phase, only the strobe's asserting (rising) transition carries a word. In a double-transition phase, both transitions carry a word, and two 16-bit check words follow the payload. The receiver compares these check words against a CRC-32 that it accumulates over the payload.

A phase begins with a one-cycle `phase_start` pulse. This pulse carries the phase type and the payload length. A double-transition phase is accepted only when the bus reports low-voltage differential signalling. Otherwise the start is refused and an error flag is raised. Payload words leave on a valid/ready stream. The bus cannot be paused, so back-pressure holds only the current output word. The sink must accept each word before the next word is captured, or the held word is replaced. A one-cycle `phase_done` pulse marks the end of the phase. `crc_err` reports the integrity verdict until the next phase start.

The payload length must be at least 1. Bus data must stay stable from the strobe transition until three clock edges later.

Top module: `dt_rx_top`

## Requirements
- R1: Synchronous reset clears `out_valid`, `phase_done`, `crc_err` and `mode_err`, and leaves the block idle, ignoring the strobe until a phase start.
- R2: In a single-transition phase, only a rising strobe transition captures a word, and falling transitions are ignored. The word appears on `out_data` with `out_valid` high after the third rising clock edge following the strobe change.
- R3: In a double-transition phase, both rising and falling strobe transitions capture a word, with the same three-edge latency as R2.
- R4: A phase start with `dt_req`=1 while `lvd_mode`=0 is refused. `mode_err` is 1 from the next cycle until the next phase start, and no strobe transition is captured meanwhile.
- R5: A double-transition phase computes CRC-32 over the payload. The polynomial is 0x04C11DB7, the register is preset to all ones, each word is fed MSB first, and there is no final inversion. After the payload, two more words are captured: first the high half of the CRC, then the low half. These two words never appear on the output stream.
- R6: If the received check words differ from the computed CRC, `crc_err` rises in the same cycle as `phase_done` and stays high until the next phase start, which clears it.
- R7: A single-transition phase captures no check words and ends after its last payload word. `crc_err` stays 0 in this phase, and `lvd_mode` has no effect on it.
- R8: `phase_done` is a one-cycle pulse. It appears in the cycle in which the final word of the phase is captured: the last payload word in a single-transition phase, or the low check word in a double-transition phase.
- R9: While `out_valid`=1 and `out_ready`=0 and no new word is captured, `out_valid` and `out_data` hold. After a cycle with `out_valid` and `out_ready` both high, and no new capture, `out_valid` is 0.
- R10: A phase start during an active phase abandons that phase. The length is reloaded, the CRC is preset, the flags are cleared, and the abandoned phase produces no `phase_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the strobe transition rate |
| rst | input | 1 | Synchronous reset, active high |
| phase_start | input | 1 | One-cycle pulse that begins a data phase |
| dt_req | input | 1 | Phase type at start: 1 = double-transition, 0 = single-transition |
| lvd_mode | input | 1 | Bus is in low-voltage differential mode |
| payload_words | input | CNT_W | Payload word count, sampled at phase start (at least 1) |
| bus_data | input | 16 | Parallel bus data |
| bus_strobe | input | 1 | Asynchronous handshake strobe |
| out_ready | input | 1 | Sink accepts the output word |
| out_valid | output | 1 | Output word is valid |
| out_data | output | 16 | Output payload word |
| phase_done | output | 1 | One-cycle end-of-phase pulse |
| crc_err | output | 1 | CRC mismatch in the last double-transition phase |
| mode_err | output | 1 | Double-transition start refused without LVD |

## Verification
The check-word comparison and the end-of-phase pulse are made in the same cycle. In a single-transition phase, the last payload word reaches the stream in the same cycle as `phase_done`. The bench provokes the first case with double-transition phases whose trailing words are correct and then deliberately corrupted. It provokes the second case with short single-transition phases. A per-cycle reference model predicts, for every clock, the output word, the done pulse and both flags, so a coincidence that lands one cycle early or late is caught.

// File: rtl/dt_rx_pkg.sv
package dt_rx_pkg;
  localparam int WORD_W = 16;
  localparam int CRC_W  = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_DATA,
    RX_CHK_HI,
    RX_CHK_LO
  } rx_state_e;

  // Advance the CRC register over one word, most significant bit first.
  function automatic logic [CRC_W-1:0] crc_advance(logic [CRC_W-1:0] cur,
                                                   logic [WORD_W-1:0] w);
    logic [CRC_W-1:0] r;
    r = cur;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (r[CRC_W-1] ^ w[i]) r = (r << 1) ^ CRC_POLY;
      else                   r = r << 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/dt_rx_edge.sv
module dt_rx_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_async,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], strobe_async};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
  assign fall = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/dt_rx_crc.sv
module dt_rx_crc
  import dt_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic              update,
  input  logic [WORD_W-1:0] word,
  output logic [CRC_W-1:0]  crc
);
  always_ff @(posedge clk) begin
    if (rst || init) crc <= CRC_SEED;
    else if (update) crc <= crc_advance(crc, word);
  end
endmodule

// File: rtl/dt_rx_count.sv
module dt_rx_count #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         last
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - W'(1);
  end

  assign last = (cnt_q == W'(1));
endmodule

// File: rtl/dt_rx_top.sv
module dt_rx_top
  import dt_rx_pkg::*;
#(
  parameter int CNT_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phase_start,
  input  logic              dt_req,
  input  logic              lvd_mode,
  input  logic [CNT_W-1:0]  payload_words,
  input  logic [WORD_W-1:0] bus_data,
  input  logic              bus_strobe,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              phase_done,
  output logic              crc_err,
  output logic              mode_err
);
  rx_state_e         state_q;
  logic              dt_q;
  logic              rise, fall;
  logic              start_ok;
  logic              cap;
  logic              cap_payload;
  logic              last_word;
  logic [CRC_W-1:0]  crc_val;
  logic [WORD_W-1:0] chk_hi_q;

  assign start_ok    = phase_start & (lvd_mode | ~dt_req);
  assign cap         = (state_q != RX_IDLE) & ~phase_start & (rise | (dt_q & fall));
  assign cap_payload = cap & (state_q == RX_DATA);

  dt_rx_edge #(.STAGES(SYNC_STAGES)) edge_i (
    .clk(clk), .rst(rst), .strobe_async(bus_strobe), .rise(rise), .fall(fall)
  );

  dt_rx_count #(.W(CNT_W)) count_i (
    .clk(clk), .rst(rst), .load(start_ok), .load_val(payload_words),
    .dec(cap_payload), .last(last_word)
  );

  dt_rx_crc crc_i (
    .clk(clk), .rst(rst), .init(start_ok), .update(cap_payload),
    .word(bus_data), .crc(crc_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= RX_IDLE;
      dt_q       <= 1'b0;
      out_valid  <= 1'b0;
      out_data   <= '0;
      phase_done <= 1'b0;
      crc_err    <= 1'b0;
      mode_err   <= 1'b0;
      chk_hi_q   <= '0;
    end else begin
      phase_done <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (phase_start) begin
        crc_err  <= 1'b0;
        mode_err <= ~start_ok;
        dt_q     <= dt_req;
        state_q  <= start_ok ? RX_DATA : RX_IDLE;
      end else if (cap) begin
        unique case (state_q)
          RX_DATA: begin
            out_data  <= bus_data;
            out_valid <= 1'b1;
            if (last_word) begin
              if (dt_q) begin
                state_q <= RX_CHK_HI;
              end else begin
                state_q    <= RX_IDLE;
                phase_done <= 1'b1;
              end
            end
          end
          RX_CHK_HI: begin
            chk_hi_q <= bus_data;
            state_q  <= RX_CHK_LO;
          end
          RX_CHK_LO: begin
            crc_err    <= ({chk_hi_q, bus_data} != crc_val);
            phase_done <= 1'b1;
            state_q    <= RX_IDLE;
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dt_rx_chk.sv
module dt_rx_chk (
  input logic        clk,
  input logic        rst,
  input logic        phase_start,
  input logic        dt_req,
  input logic        lvd_mode,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_data,
  input logic        phase_done,
  input logic        crc_err,
  input logic        mode_err,
  input logic        cap
);
  // R8: end-of-phase pulse lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    phase_done |=> !phase_done);

  // R9: held word is stable under back-pressure
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !cap) |=> (out_valid && $stable(out_data)));

  // R6: CRC error only appears together with the end of phase
  a_r6_crc_with_done: assert property (@(posedge clk) disable iff (rst)
    $rose(crc_err) |-> phase_done);

  // R4: refused start raises the mode error
  a_r4_mode_err_set: assert property (@(posedge clk) disable iff (rst)
    (phase_start && dt_req && !lvd_mode) |=> mode_err);

  // R4: nothing is captured while the mode error is held
  a_r4_no_capture: assert property (@(posedge clk) disable iff (rst)
    mode_err |-> !cap);
endmodule

bind dt_rx_top dt_rx_chk chk_i (
  .clk(clk), .rst(rst), .phase_start(phase_start), .dt_req(dt_req),
  .lvd_mode(lvd_mode), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .phase_done(phase_done), .crc_err(crc_err),
  .mode_err(mode_err), .cap(cap)
);

// File: tb/dt_rx_top_tb_top.sv
`timescale 1ns/1ps
module dt_rx_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        phase_start = 1'b0;
  logic        dt_req = 1'b0;
  logic        lvd_mode = 1'b1;
  logic [11:0] payload_words = '0;
  logic [15:0] bus_data = '0;
  logic        bus_strobe = 1'b0;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic [15:0] out_data;
  logic        phase_done;
  logic        crc_err;
  logic        mode_err;

  always #2 clk = ~clk;

  dt_rx_top dut_i (
    .clk(clk), .rst(rst), .phase_start(phase_start), .dt_req(dt_req),
    .lvd_mode(lvd_mode), .payload_words(payload_words), .bus_data(bus_data),
    .bus_strobe(bus_strobe), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .phase_done(phase_done), .crc_err(crc_err),
    .mode_err(mode_err)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int rcv    = 0;
  int dones  = 0;
  bit run    = 1'b0;
  bit mon_v  = 1'b1;

  // reference model schedule, keyed by cycle
  bit          exp_v[int];
  logic [15:0] exp_d[int];
  bit          exp_done[int];
  bit          crc_chg[int];
  bit          mode_chg[int];
  bit          exp_crc  = 1'b0;
  bit          exp_mode = 1'b0;

  // reference model phase state
  bit          m_active = 1'b0;
  bit          m_dt = 1'b0;
  int          m_left = 0;
  int          m_chk = 0;
  logic [31:0] m_crc = '1;
  logic [15:0] m_hi = '0;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] ref_crc(logic [31:0] c, logic [15:0] w);
    logic [31:0] r = c;
    for (int b = 15; b >= 0; b--) begin
      logic fb = r[31] ^ w[b];
      r = {r[30:0], 1'b0};
      if (fb) r = r ^ 32'h04C11DB7;
    end
    return r;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && out_valid && out_ready) rcv <= rcv + 1;
    if (!rst && phase_done) dones <= dones + 1;
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (run) begin
      if (crc_chg.exists(cyc)) exp_crc = crc_chg[cyc];
      if (mode_chg.exists(cyc)) exp_mode = mode_chg[cyc];
      if (mon_v) begin
        check(out_valid == exp_v.exists(cyc), "R2 R3", "out_valid",
              32'(out_valid), 32'(exp_v.exists(cyc)));
        if (exp_v.exists(cyc))
          check(out_data == exp_d[cyc], "R2 R3", "out_data", 32'(out_data), 32'(exp_d[cyc]));
      end
      check(phase_done == exp_done.exists(cyc), "R8", "phase_done",
            32'(phase_done), 32'(exp_done.exists(cyc)));
      check(crc_err == exp_crc, "R6", "crc_err", 32'(crc_err), 32'(exp_crc));
      check(mode_err == exp_mode, "R4", "mode_err", 32'(mode_err), 32'(exp_mode));
    end
  end

  task automatic start_phase(bit dt, bit lvd, int n);
    @(negedge clk);
    phase_start   = 1'b1;
    dt_req        = dt;
    lvd_mode      = lvd;
    payload_words = 12'(n);
    crc_chg[cyc + 1] = 1'b0;
    if (dt && !lvd) begin
      mode_chg[cyc + 1] = 1'b1;
      m_active = 1'b0;
    end else begin
      mode_chg[cyc + 1] = 1'b0;
      m_active = 1'b1;
      m_dt     = dt;
      m_left   = n;
      m_chk    = 0;
      m_crc    = '1;
    end
    @(negedge clk);
    phase_start = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // one strobe transition carrying d; called at a falling clock edge
  task automatic toggle(logic [15:0] d);
    int due;
    bus_data   = d;
    bus_strobe = ~bus_strobe;
    due = cyc + 3;
    if (m_active && (bus_strobe || m_dt)) begin
      if (m_left > 0) begin
        exp_v[due] = 1'b1;
        exp_d[due] = d;
        m_crc = ref_crc(m_crc, d);
        m_left--;
        if (m_left == 0 && !m_dt) begin
          exp_done[due] = 1'b1;
          m_active = 1'b0;
        end
      end else if (m_chk == 0) begin
        m_hi  = d;
        m_chk = 1;
      end else begin
        exp_done[due] = 1'b1;
        crc_chg[due]  = ({m_hi, d} != m_crc);
        m_active = 1'b0;
      end
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic st_word(logic [15:0] d);
    toggle(d);
    toggle(~d);
  endtask

  task automatic dt_phase(int n, logic [15:0] seed, bit corrupt);
    logic [31:0] c = '1;
    start_phase(1'b1, 1'b1, n);
    for (int k = 0; k < n; k++) begin
      logic [15:0] w = seed ^ 16'(k * 16'h1357);
      c = ref_crc(c, w);
      toggle(w);
    end
    toggle(c[31:16]);
    toggle(corrupt ? (c[15:0] ^ 16'h0100) : c[15:0]);
  endtask

  initial begin
    int r0;
    int d0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(out_valid == 0 && phase_done == 0, "R1", "valid/done after reset",
          {out_valid, phase_done}, 0);
    check(crc_err == 0 && mode_err == 0, "R1", "flags after reset", {crc_err, mode_err}, 0);
    run = 1'b1;
    // R1: strobe ignored while idle
    toggle(16'hDEAD);
    toggle(16'hBEEF);
    check(rcv == 0, "R1", "words captured while idle", rcv, 0);

    // R2: single-transition phase, falling edges ignored
    r0 = rcv;
    start_phase(1'b0, 1'b1, 4);
    st_word(16'h1111); st_word(16'hA5A5); st_word(16'h0F0F); st_word(16'hFFFF);
    check(rcv == r0 + 4, "R2", "single-transition word count", rcv - r0, 4);

    // R3 R5: double-transition with correct CRC, check words not forwarded
    r0 = rcv;
    dt_phase(4, 16'h3C5A, 1'b0);
    check(rcv == r0 + 4, "R5", "check words forwarded", rcv - r0, 4);
    check(crc_err == 0, "R5", "good CRC flagged", crc_err, 0);

    // R6: corrupted check word, held until the next start
    dt_phase(6, 16'h8001, 1'b0);
    dt_phase(4, 16'h7777, 1'b1);
    repeat (5) @(negedge clk);
    check(crc_err == 1, "R6", "crc_err held after mismatch", crc_err, 1);

    // R4: refused double-transition start without LVD
    r0 = rcv;
    start_phase(1'b1, 1'b0, 2);
    toggle(16'h4444); toggle(16'h5555); toggle(16'h6666); toggle(16'h7777);
    check(rcv == r0 && mode_err == 1, "R4", "capture after refused start", rcv - r0, 0);
    check(crc_err == 0, "R6", "start clears crc_err", crc_err, 0);

    // R7: single-transition phase without LVD, no CRC step
    r0 = rcv;
    d0 = dones;
    start_phase(1'b0, 1'b0, 3);
    st_word(16'h0001); st_word(16'h8000); st_word(16'h1234);
    check(rcv == r0 + 3 && dones == d0 + 1, "R7", "ST phase end", rcv - r0, 3);
    check(crc_err == 0 && mode_err == 0, "R7", "flags in ST phase", {crc_err, mode_err}, 0);

    // R10: restart abandons a running double-transition phase
    d0 = dones;
    start_phase(1'b1, 1'b1, 4);
    toggle(16'h2222); toggle(16'h3333);
    start_phase(1'b0, 1'b1, 2);
    st_word(16'h9999); st_word(16'hAAAA);
    check(dones == d0 + 1, "R10", "done count after restart", dones - d0, 1);

    // R9: back-pressure holds the word
    mon_v = 1'b0;
    out_ready = 1'b0;
    start_phase(1'b0, 1'b1, 1);
    toggle(16'hC0DE);
    check(out_valid == 1 && out_data == 16'hC0DE, "R9", "held word", out_data, 16'hC0DE);
    repeat (3) @(negedge clk);
    check(out_valid == 1 && out_data == 16'hC0DE, "R9", "still held", out_data, 16'hC0DE);
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid == 0, "R9", "valid after accept", out_valid, 0);
    toggle(16'h0000);
    mon_v = 1'b1;
    repeat (4) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule